// File: doc/BRIEF.md
# Level-Sensitive Cause/Mask Interrupt Controller

This block gathers up to 32 level-sensitive interrupt inputs and merges them into one request line for an upstream, cascaded interrupt controller. Each input has a latched cause bit and an enable bit. A source whose input is high sets its cause bit on every clock. Software acknowledges a source by writing a one to its cause bit. The request line goes high when any cause bit is set while its enable bit is also set.

Software reaches the registers through a small 32-bit register port with a valid/ready handshake. The port is always ready, and read data returns one cycle after the request. A read-only status word gives the number of the lowest-numbered pending and enabled source, together with a valid flag, so a handler can find which source to serve without scanning bits. To quiesce the block, write all zeros to the enable register and then all ones to the cause register.

Top module: `level_irq_ctrl`

## Requirements
- R1: After reset the cause register, the enable register, the status word and `irq_out` are all zero.
- R2: A cause bit is set at the first clock edge where its source input is high. It stays set after the input falls, until software acknowledges it. A bit never sets while its input is low.
- R3: Byte offset 0x04 holds the enable register. A written value reads back unchanged. Bit k = 1 enables source k and bit k = 0 disables it. Disabling a source does not change its cause bit.
- R4: Byte offset 0x00 holds the cause register. Writing a 1 to bit k clears cause bit k. Writing a 0 leaves that bit as it was.
- R5: A source whose input is still high when it is acknowledged stays set in the cause register.
- R6: When a source input is high in the same cycle that its cause bit receives a write-one-to-clear, the set wins and the bit remains 1.
- R7: `irq_out` is the OR of (cause AND enable), delayed by one register stage. It rises one cycle after a pending bit appears and falls one cycle after the last pending bit goes away.
- R8: When several sources are pending, the status word reports the lowest-numbered one.
- R9: Byte offset 0x08 is a read-only status word. Bit 31 is set when some source is pending and enabled, and bits 4:0 hold the index of the lowest such source. The word reads as zero when nothing is pending.
- R10: Any offset other than 0x00, 0x04 and 0x08, misaligned offsets included, reads as zero, and writes to it change no register.
- R11: Writing 0 to the enable register and then 0xFFFFFFFF to the cause register (with all inputs low) clears every cause bit and drives `irq_out` low.
- R12: A read returns its data on `reg_rdata` one cycle after the request, with `reg_rvalid` high in that cycle. `reg_ready` is always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 32 | Level-sensitive source inputs, one per source |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_out | output | 1 | Combined registered request toward the upstream controller |

## Verification
The bench walks a single latched source through all 32 positions and sweeps the enable register as a moving threshold over a fully set cause register. A wrong priority encoder or a swapped field would then report the wrong index or drop the valid bit. It holds an input high across its own acknowledge: a design where the clear wins would lose the bit, and one that ignores zero bits in the acknowledge word would wipe neighbouring bits. It times `irq_out` to the exact cycle, so a combinational or two-stage output is caught. It also writes to a hole in the map, so a loose address decode that aliases onto the enable register would change the enables.

// File: rtl/level_irq_pkg.sv
package level_irq_pkg;
    localparam int unsigned OFS_CAUSE  = 0;
    localparam int unsigned OFS_ENABLE = 4;
    localparam int unsigned OFS_STATUS = 8;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] cause_o
);
    logic [N-1:0] cause_d, cause_q;

    always_comb begin
        // clear first, then set: a live source overrides the acknowledge
        cause_d = (cause_q & ~clr_i) | src_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause_o = cause_q;

    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((cause_q & $past(src_i)) == $past(src_i)));

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & clr_i) != '0) |=> ((cause_q & $past(src_i & clr_i)) == $past(src_i & clr_i)));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~src_i) != '0) |=> ((cause_q & $past(clr_i & ~src_i)) == '0));

    assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(src_i)) == '0));
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
    parameter int unsigned N  = 32,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);
    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        // scan downward so the last hit, the lowest index, wins
        for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[k]) begin
                idx_o   = IW'(k);
                valid_o = 1'b1;
            end
        end
    end

    assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vec_i[idx_o] && ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0)));

    assert_valid_means_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (vec_i == '0));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import level_irq_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      cause_i,
    input  logic [IW-1:0]     idx_i,
    input  logic              pend_i,
    output logic [N-1:0]      enable_o,
    output logic [N-1:0]      clr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFS_CAUSE);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [N-1:0]      enable;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } port_state_t;

    port_state_t st_d, st_q;
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word             = '0;
        status_word[DATA_W-1]   = pend_i;
        status_word[IW-1:0]     = idx_i;

        st_d        = st_q;
        st_d.rvalid = 1'b0;
        clr_o       = '0;
        if (valid_i) begin
            if (write_i) begin
                if (addr_i == A_ENABLE) st_d.enable = wdata_i[N-1:0];
                if (addr_i == A_CAUSE)  clr_o       = wdata_i[N-1:0];
            end else begin
                st_d.rvalid = 1'b1;
                unique case (addr_i)
                    A_CAUSE:  st_d.rdata = DATA_W'(cause_i);
                    A_ENABLE: st_d.rdata = DATA_W'(st_q.enable);
                    A_STATUS: st_d.rdata = status_word;
                    default:  st_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.enable;
    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && addr_i == A_ENABLE) |=> (enable_o == $past(wdata_i[N-1:0])));

    assert_hole_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && write_i && addr_i != A_ENABLE) |=> $stable(enable_o));

    assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !write_i) |=> rvalid_o);
endmodule

// File: rtl/level_irq_ctrl.sv
module level_irq_ctrl #(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      irq_src,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ready,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_out
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t    tp_d, tp_q;
    logic [N-1:0]  cause, enable, clr, pending;
    logic [IW-1:0] low_idx;
    logic          any_pend;

    irq_cause_bank #(.N(N)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (irq_src),
        .clr_i   (clr),
        .cause_o (cause)
    );

    assign pending = cause & enable;

    irq_lowest_enc #(.N(N)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .vec_i   (pending),
        .idx_o   (low_idx),
        .valid_o (any_pend)
    );

    irq_reg_port #(.N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (reg_valid),
        .write_i  (reg_write),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .cause_i  (cause),
        .idx_i    (low_idx),
        .pend_i   (any_pend),
        .enable_o (enable),
        .clr_o    (clr),
        .rdata_o  (reg_rdata),
        .rvalid_o (reg_rvalid)
    );

    always_comb begin
        tp_d     = tp_q;
        tp_d.irq = any_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign irq_out   = tp_q.irq;
    assign reg_ready = 1'b1;

    assert_quiet_when_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> !irq_out);

    assert_irq_from_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & enable) != '0) |=> irq_out);
endmodule

// File: tb/sim_level_irq_ctrl.sv
module sim_level_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] OF_CAUSE  = 4'h0;
    localparam logic [3:0] OF_ENABLE = 4'h4;
    localparam logic [3:0] OF_STATUS = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    level_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        if (!reg_rvalid) begin
            checks++; fails++;
            $display("FAIL R12: actual rvalid 0 expected 1");
        end
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
        irq_src = '0;
    endtask

    function automatic logic [31:0] stat_of(input logic [31:0] p);
        logic [31:0] r = '0;
        for (int k = 31; k >= 0; k--)
            if (p[k]) r = 32'h8000_0000 | 32'(k);
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq_out", {31'b0, irq_out}, 32'h0);
        check("R12 ready", {31'b0, reg_ready}, 32'h1);
        rdreg(OF_CAUSE, rd);  check("R1 cause", rd, 32'h0);
        rdreg(OF_ENABLE, rd); check("R1 enable", rd, 32'h0);
        rdreg(OF_STATUS, rd); check("R1 status", rd, 32'h0);

        // R2/R9/R4 walk a single source through every position
        wr(OF_ENABLE, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            pulse(32'h1 << i);
            rdreg(OF_CAUSE, rd);  check("R2 cause latch", rd, 32'h1 << i);
            rdreg(OF_STATUS, rd); check("R9 status index", rd, 32'h8000_0000 | 32'(i));
            check("R7 irq high", {31'b0, irq_out}, 32'h1);
            wr(OF_CAUSE, 32'h1 << i);
            rdreg(OF_CAUSE, rd);  check("R4 w1c clear", rd, 32'h0);
            check("R7 irq low", {31'b0, irq_out}, 32'h0);
        end

        // R8 two sources at once, lowest wins
        for (int i = 0; i < 32; i++) begin
            logic [31:0] two;
            two = (32'h1 << i) | (32'h1 << ((i * 7 + 3) % 32));
            pulse(two);
            rdreg(OF_STATUS, rd); check("R8 lowest of pair", rd, stat_of(two));
            wr(OF_CAUSE, 32'hFFFF_FFFF);
        end

        // R3 enable as a moving threshold over a full cause register
        pulse(32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            wr(OF_ENABLE, 32'hFFFF_FFFF << i);
            rdreg(OF_ENABLE, rd); check("R3 enable readback", rd, 32'hFFFF_FFFF << i);
            rdreg(OF_STATUS, rd); check("R3 masked status", rd, 32'h8000_0000 | 32'(i));
        end
        wr(OF_ENABLE, 32'h0);
        @(negedge clk);
        check("R3 disabled irq", {31'b0, irq_out}, 32'h0);
        rdreg(OF_STATUS, rd); check("R9 status empty", rd, 32'h0);
        rdreg(OF_CAUSE, rd);  check("R3 cause kept when disabled", rd, 32'hFFFF_FFFF);

        // R4 zero bits of an acknowledge leave the cause alone
        wr(OF_CAUSE, 32'h0);
        rdreg(OF_CAUSE, rd); check("R4 write zero keeps", rd, 32'hFFFF_FFFF);
        wr(OF_CAUSE, 32'h0000_FFFF);
        rdreg(OF_CAUSE, rd); check("R4 partial w1c", rd, 32'hFFFF_0000);

        // R5/R6 source held high through its acknowledge
        @(negedge clk); irq_src = 32'h0000_0020;
        wr(OF_CAUSE, 32'hFFFF_FFFF);
        rdreg(OF_CAUSE, rd); check("R5 R6 level survives ack", rd, 32'h0000_0020);
        @(negedge clk); irq_src = '0;
        wr(OF_CAUSE, 32'h0000_0020);
        rdreg(OF_CAUSE, rd); check("R5 clears after drop", rd, 32'h0);

        // R7 exact latency of irq_out
        wr(OF_ENABLE, 32'hFFFF_FFFF);
        @(negedge clk); irq_src = 32'h8;
        @(negedge clk); irq_src = '0;
        check("R7 not yet high", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R7 high after one stage", {31'b0, irq_out}, 32'h1);
        wr(OF_CAUSE, 32'h8);
        check("R7 still high at clear edge", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R7 low one cycle later", {31'b0, irq_out}, 32'h0);

        // R10 holes in the map
        pulse(32'h0000_0100);
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h5, 32'h0);
        rdreg(4'hC, rd);      check("R10 hole reads zero", rd, 32'h0);
        rdreg(4'h2, rd);      check("R10 misaligned reads zero", rd, 32'h0);
        rdreg(OF_ENABLE, rd); check("R10 enable untouched", rd, 32'hFFFF_FFFF);
        rdreg(OF_CAUSE, rd);  check("R10 cause untouched", rd, 32'h0000_0100);
        wr(OF_STATUS, 32'h0);
        rdreg(OF_STATUS, rd); check("R10 status read-only", rd, 32'h8000_0008);

        // R11 quiesce sequence
        pulse(32'hA5A5_0F0F);
        check("R11 irq before quiesce", {31'b0, irq_out}, 32'h1);
        wr(OF_ENABLE, 32'h0);
        wr(OF_CAUSE, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R11 irq after quiesce", {31'b0, irq_out}, 32'h0);
        rdreg(OF_CAUSE, rd);  check("R11 cause empty", rd, 32'h0);
        rdreg(OF_STATUS, rd); check("R11 status empty", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule